// File: doc/BRIEF.md
# Microcontroller ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit microcontroller datapath. It receives one or two byte operands, a 6-bit immediate for word operations, a 4-bit operation code and the current status byte. It returns a result of up to 16 bits and the updated status byte. All outputs are captured in one output register stage, so a result appears one clock after the operation is offered.

The block covers byte addition and subtraction, with and without the incoming carry. It also covers increment, decrement, bitwise complement, two's-complement negate, exclusive-or, add and subtract of an immediate on a 16-bit register pair, and an unsigned 8x8 multiply. Each operation updates only the flags its rule names. All other flag bits, and always the transfer and interrupt-enable bits, come through from the status input unchanged. Register file access, decode and memory are left to the surrounding core.

Top module: `mcu_alu`

## Requirements
- R1: The status byte uses bit 0 for carry (C), bit 1 for zero (Z), bit 2 for negative (N), bit 3 for signed overflow (V), bit 4 for sign (S), bit 5 for half carry (H), bit 6 for transfer (T) and bit 7 for interrupt enable (I). Every operation that writes N and V also writes S as N xor V.
- R2: When valid_i is high at a rising edge, res_o, sreg_o and a high valid_o appear after that edge. When valid_i is low, valid_o goes low and res_o and sreg_o hold their values. Reset clears all three outputs.
- R3: ADD (code 0) and ADC (code 1) return a+b, with ADC adding C, wrapped to 8 bits. C is the carry out of bit 7, H the carry out of bit 3 and V the signed overflow. For example 0xFF+0xFF gives 0xFE with C set.
- R4: SUB (code 2) and SBC (code 3) return a-b, with SBC also subtracting C. C is the borrow out of bit 7, H the borrow into bit 4 and V the signed overflow.
- R5: SBC leaves Z set only if it was already set and the result is zero. A nonzero result clears Z.
- R6: INC (code 4) and DEC (code 5) add or subtract one and leave C and H unchanged. V is set when INC gives 0x80 or DEC gives 0x7F.
- R7: COM (code 6) returns the bitwise inverse of a, sets C, clears V and leaves H unchanged.
- R8: NEG (code 7) returns 0-a. C is set when the result is nonzero, V when it is 0x80, and H is the borrow into bit 4.
- R9: EOR (code 8) returns a xor b, clears V and leaves C and H unchanged.
- R10: ADIW (code 9) and SBIW (code 10) add or subtract the zero-extended immediate on the pair {b_i,a_i}, with b_i the high byte. N is taken from bit 15 and Z from the whole 16-bit result. C and V follow from bit 15 of the result and bit 7 of the high byte. H is unchanged.
- R11: MUL (code 11) returns the unsigned 16-bit product in res_o, with the high byte in bits 15:8. C is product bit 15 and Z is set for a zero product. N, V, S and H are unchanged.
- R12: T and I pass through for every code. Codes 12 to 15 return zero and leave the whole status byte unchanged.
- R13: For byte operations, res_o[15:8] is zero, Z reflects a zero byte result (except under R5) and N is result bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation offered this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand, low byte of a word pair |
| b_i | input | 8 | Second operand, high byte of a word pair |
| imm_i | input | 6 | Immediate for word operations |
| sreg_i | input | 8 | Current status byte |
| valid_o | output | 1 | Result registered from an offered operation |
| res_o | output | 16 | Result |
| sreg_o | output | 8 | Updated status byte |

## Verification
Every result and flag is due exactly one rising edge after the cycle in which valid_i is high. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the following falling edge. This places every check in the single cycle where the registered outputs first show the operation. The hold case drops valid_i with altered inputs and samples after the next edge, to confirm that nothing moved.

// File: rtl/mcu_alu_pkg.sv
package mcu_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_COM  = 4'd6,
    OP_NEG  = 4'd7,
    OP_EOR  = 4'd8,
    OP_ADIW = 4'd9,
    OP_SBIW = 4'd10,
    OP_MUL  = 4'd11
  } alu_op_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;
  localparam int FLAG_H = 5;
  localparam int FLAG_T = 6;
  localparam int FLAG_I = 7;
endpackage

// File: rtl/mcu_alu_addsub.sv
module mcu_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         h_o,
  output logic         v_o
);
  localparam int HB = W/2 - 1;
  localparam int MB = W - 1;

  logic [W-1:0] b_eff;
  logic         ci;
  logic [W:0]   sum;

  // subtract as a + ~b + ~borrow_in
  assign b_eff = sub_i ? ~b_i : b_i;
  assign ci    = sub_i ? ~cin_i : cin_i;
  assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, ci};
  assign res_o = sum[W-1:0];
  assign c_o   = sub_i ? ~sum[W] : sum[W];

  always_comb begin
    if (sub_i) begin
      h_o = (~a_i[HB] & b_i[HB]) | (b_i[HB] & res_o[HB]) | (res_o[HB] & ~a_i[HB]);
      v_o = (a_i[MB] & ~b_i[MB] & ~res_o[MB]) | (~a_i[MB] & b_i[MB] & res_o[MB]);
    end else begin
      h_o = (a_i[HB] & b_i[HB]) | (b_i[HB] & ~res_o[HB]) | (~res_o[HB] & a_i[HB]);
      v_o = (a_i[MB] & b_i[MB] & ~res_o[MB]) | (~a_i[MB] & ~b_i[MB] & res_o[MB]);
    end
  end
endmodule

// File: rtl/mcu_alu_word.sv
module mcu_alu_word #(
  parameter int W     = 8,
  parameter int IMM_W = 6
) (
  input  logic [W-1:0]     lo_i,
  input  logic [W-1:0]     hi_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             sub_i,
  output logic [2*W-1:0]   res_o,
  output logic             c_o,
  output logic             v_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] pair;
  logic [PW-1:0] ext;
  logic          h_top;
  logic          r_top;

  assign pair  = {hi_i, lo_i};
  assign ext   = {{(PW-IMM_W){1'b0}}, imm_i};
  assign res_o = sub_i ? (pair - ext) : (pair + ext);
  assign h_top = hi_i[W-1];
  assign r_top = res_o[PW-1];
  assign c_o   = sub_i ? (r_top & ~h_top) : (~r_top & h_top);
  assign v_o   = sub_i ? (h_top & ~r_top) : (~h_top & r_top);
endmodule

// File: rtl/mcu_alu_mul.sv
module mcu_alu_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] part [W];

  // shift-add partial products, summed in a chain
  for (genvar i = 0; i < W; i++) begin : g_pp
    logic [PW-1:0] row;
    assign row = b_i[i] ? ({{W{1'b0}}, a_i} << i) : '0;
    if (i == 0) begin : g_first
      assign part[i] = row;
    end else begin : g_next
      assign part[i] = part[i-1] + row;
    end
  end

  assign prod_o = part[W-1];
endmodule

// File: rtl/mcu_alu.sv
module mcu_alu
  import mcu_alu_pkg::*;
#(
  parameter int W     = 8,
  parameter int IMM_W = 6,
  parameter int SW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [SW-1:0]    sreg_i,
  output logic             valid_o,
  output logic [2*W-1:0]   res_o,
  output logic [SW-1:0]    sreg_o
);
  localparam int PW = 2 * W;
  localparam int MB = W - 1;
  localparam logic [W-1:0] ONE     = W'(1);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // shared byte adder/subtractor
  logic [W-1:0] as_a, as_b, as_res;
  logic         as_cin, as_sub, as_c, as_h, as_v;

  assign as_a   = (op == OP_NEG) ? '0 : a_i;
  assign as_b   = (op == OP_NEG) ? a_i : b_i;
  assign as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? sreg_i[FLAG_C] : 1'b0;
  assign as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_NEG);

  mcu_alu_addsub #(.W(W)) u_addsub (
    .a_i   (as_a),
    .b_i   (as_b),
    .cin_i (as_cin),
    .sub_i (as_sub),
    .res_o (as_res),
    .c_o   (as_c),
    .h_o   (as_h),
    .v_o   (as_v)
  );

  logic [PW-1:0] wd_res;
  logic          wd_c, wd_v;

  mcu_alu_word #(.W(W), .IMM_W(IMM_W)) u_word (
    .lo_i  (a_i),
    .hi_i  (b_i),
    .imm_i (imm_i),
    .sub_i (op == OP_SBIW),
    .res_o (wd_res),
    .c_o   (wd_c),
    .v_o   (wd_v)
  );

  logic [PW-1:0] prod;

  mcu_alu_mul #(.W(W)) u_mul (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod)
  );

  logic [W-1:0]  byte_res;
  logic          byte_op;
  logic [PW-1:0] nxt_res;
  logic [SW-1:0] nxt_sreg;

  always_comb begin
    byte_res = '0;
    byte_op  = 1'b1;
    nxt_res  = '0;
    nxt_sreg = sreg_i;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        byte_res         = as_res;
        nxt_sreg[FLAG_C] = (op == OP_NEG) ? (as_res != '0) : as_c;
        nxt_sreg[FLAG_H] = as_h;
        nxt_sreg[FLAG_V] = as_v;
      end
      OP_INC: begin
        byte_res         = a_i + ONE;
        nxt_sreg[FLAG_V] = (byte_res == MIN_NEG);
      end
      OP_DEC: begin
        byte_res         = a_i - ONE;
        nxt_sreg[FLAG_V] = (byte_res == MAX_POS);
      end
      OP_COM: begin
        byte_res         = ~a_i;
        nxt_sreg[FLAG_C] = 1'b1;
        nxt_sreg[FLAG_V] = 1'b0;
      end
      OP_EOR: begin
        byte_res         = a_i ^ b_i;
        nxt_sreg[FLAG_V] = 1'b0;
      end
      OP_ADIW, OP_SBIW: begin
        byte_op          = 1'b0;
        nxt_res          = wd_res;
        nxt_sreg[FLAG_C] = wd_c;
        nxt_sreg[FLAG_V] = wd_v;
        nxt_sreg[FLAG_N] = wd_res[PW-1];
        nxt_sreg[FLAG_Z] = (wd_res == '0);
        nxt_sreg[FLAG_S] = wd_res[PW-1] ^ wd_v;
      end
      OP_MUL: begin
        byte_op          = 1'b0;
        nxt_res          = prod;
        nxt_sreg[FLAG_C] = prod[PW-1];
        nxt_sreg[FLAG_Z] = (prod == '0);
      end
      default: begin
        byte_op = 1'b0;
      end
    endcase

    if (byte_op) begin
      nxt_res          = {{W{1'b0}}, byte_res};
      nxt_sreg[FLAG_N] = byte_res[MB];
      // SBC: zero only survives if it held before
      nxt_sreg[FLAG_Z] = (byte_res == '0) & ((op != OP_SBC) | sreg_i[FLAG_Z]);
      nxt_sreg[FLAG_S] = byte_res[MB] ^ nxt_sreg[FLAG_V];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      sreg_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o  <= nxt_res;
        sreg_o <= nxt_sreg;
      end
    end
  end

  logic writes_nv;
  assign writes_nv = (op_i <= 4'd10);

  assert_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(res_o) && $stable(sreg_o)));

  assert_sign_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && writes_nv) |=> (sreg_o[FLAG_S] == (sreg_o[FLAG_N] ^ sreg_o[FLAG_V])));

  assert_ti_pass_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (sreg_o[FLAG_I:FLAG_T] == $past(sreg_i[FLAG_I:FLAG_T])));

  assert_com_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd6) |=> (sreg_o[FLAG_C] && !sreg_o[FLAG_V]));

  assert_incdec_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd4 || op_i == 4'd5)) |=>
      (sreg_o[FLAG_C] == $past(sreg_i[FLAG_C]) && sreg_o[FLAG_H] == $past(sreg_i[FLAG_H])));

  assert_byte_hi_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 4'd8) |=> (res_o[PW-1:W] == '0));
endmodule

// File: tb/tb_mcu_alu.sv
`timescale 1ns/1ps
module tb_mcu_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [7:0]  a_i = '0, b_i = '0, sreg_i = '0;
  logic [5:0]  imm_i = '0;
  logic        valid_o;
  logic [15:0] res_o;
  logic [7:0]  sreg_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  mcu_alu dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .imm_i   (imm_i),
    .sreg_i  (sreg_i),
    .valid_o (valid_o),
    .res_o   (res_o),
    .sreg_o  (sreg_o)
  );

  task automatic check(string req, logic [15:0] exp_res, logic [7:0] exp_sreg, logic exp_vld);
    checks++;
    if (res_o !== exp_res || sreg_o !== exp_sreg || valid_o !== exp_vld) begin
      errors++;
      $display("FAIL %s: res=%h sreg=%h vld=%b expected res=%h sreg=%h vld=%b",
               req, res_o, sreg_o, valid_o, exp_res, exp_sreg, exp_vld);
    end
  endtask

  // offer one operation, sample one edge later on the falling edge
  task automatic run(string req, logic [3:0] op, logic [7:0] a, logic [7:0] b,
                     logic [5:0] imm, logic [7:0] s, logic [15:0] er, logic [7:0] es);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; imm_i = imm; sreg_i = s; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(req, er, es, 1'b1);
  endtask

  task automatic t_reset;
    check("R2 reset", 16'h0000, 8'h00, 1'b0);
  endtask

  task automatic t_add;
    run("R3 add ff+ff", 4'd0, 8'hFF, 8'hFF, 6'd0, 8'hC0, 16'h00FE, 8'hF5);
    run("R3 add overflow", 4'd0, 8'h7F, 8'h01, 6'd0, 8'h00, 16'h0080, 8'h2C);
    run("R3 adc carry in", 4'd1, 8'h10, 8'h20, 6'd0, 8'h01, 16'h0031, 8'h00);
  endtask

  task automatic t_sub;
    run("R4 sub borrow", 4'd2, 8'h10, 8'h20, 6'd0, 8'h00, 16'h00F0, 8'h15);
    run("R4 sub overflow", 4'd2, 8'h80, 8'h01, 6'd0, 8'h00, 16'h007F, 8'h38);
    run("R4 sbc borrow in", 4'd3, 8'h00, 8'h00, 6'd0, 8'h01, 16'h00FF, 8'h35);
  endtask

  task automatic t_sbc_zero;
    run("R5 sbc z kept", 4'd3, 8'h05, 8'h05, 6'd0, 8'h02, 16'h0000, 8'h02);
    run("R5 sbc z not set", 4'd3, 8'h05, 8'h05, 6'd0, 8'h00, 16'h0000, 8'h00);
    run("R5 sbc z with c", 4'd3, 8'h05, 8'h04, 6'd0, 8'h03, 16'h0000, 8'h02);
  endtask

  task automatic t_incdec;
    run("R6 inc 7f", 4'd4, 8'h7F, 8'h00, 6'd0, 8'h21, 16'h0080, 8'h2D);
    run("R6 inc wrap", 4'd4, 8'hFF, 8'h00, 6'd0, 8'h00, 16'h0000, 8'h02);
    run("R6 dec 80", 4'd5, 8'h80, 8'h00, 6'd0, 8'h01, 16'h007F, 8'h19);
    run("R6 dec wrap", 4'd5, 8'h00, 8'h00, 6'd0, 8'h00, 16'h00FF, 8'h14);
  endtask

  task automatic t_com;
    run("R7 com", 4'd6, 8'h5A, 8'h00, 6'd0, 8'hC0, 16'h00A5, 8'hD5);
    run("R7 com zero", 4'd6, 8'hFF, 8'h00, 6'd0, 8'h20, 16'h0000, 8'h23);
  endtask

  task automatic t_neg;
    run("R8 neg 01", 4'd7, 8'h01, 8'h00, 6'd0, 8'h00, 16'h00FF, 8'h35);
    run("R8 neg 00", 4'd7, 8'h00, 8'h00, 6'd0, 8'h00, 16'h0000, 8'h02);
    run("R8 neg 80", 4'd7, 8'h80, 8'h00, 6'd0, 8'h00, 16'h0080, 8'h0D);
  endtask

  task automatic t_eor;
    run("R9 eor", 4'd8, 8'hF0, 8'h0F, 6'd0, 8'h29, 16'h00FF, 8'h35);
    run("R9 eor self", 4'd8, 8'h3C, 8'h3C, 6'd0, 8'h00, 16'h0000, 8'h02);
  endtask

  task automatic t_word;
    run("R10 adiw byte carry", 4'd9, 8'hFF, 8'h00, 6'd1, 8'h00, 16'h0100, 8'h00);
    run("R10 adiw wrap", 4'd9, 8'hC1, 8'hFF, 6'h3F, 8'h00, 16'h0000, 8'h03);
    run("R10 adiw overflow", 4'd9, 8'hFF, 8'h7F, 6'd1, 8'hC0, 16'h8000, 8'hCC);
    run("R10 sbiw borrow", 4'd10, 8'h00, 8'h00, 6'd1, 8'h20, 16'hFFFF, 8'h35);
    run("R10 sbiw overflow", 4'd10, 8'h00, 8'h80, 6'd1, 8'h00, 16'h7FFF, 8'h18);
  endtask

  task automatic t_mul;
    run("R11 mul ff*ff", 4'd11, 8'hFF, 8'hFF, 6'd0, 8'h2C, 16'hFE01, 8'h2D);
    run("R11 mul zero", 4'd11, 8'h00, 8'h37, 6'd0, 8'h01, 16'h0000, 8'h02);
    run("R11 mul small", 4'd11, 8'h10, 8'h08, 6'd0, 8'h03, 16'h0080, 8'h00);
  endtask

  task automatic t_unknown;
    run("R12 unused code", 4'd15, 8'h12, 8'h34, 6'd5, 8'hA5, 16'h0000, 8'hA5);
    run("R12 ti pass", 4'd0, 8'h01, 8'h01, 6'd0, 8'h40, 16'h0002, 8'h40);
  endtask

  task automatic t_hold;
    run("R2 load", 4'd0, 8'h11, 8'h22, 6'd0, 8'h00, 16'h0033, 8'h00);
    @(negedge clk_i);
    op_i = 4'd6; a_i = 8'h00; sreg_i = 8'hFF; valid_i = 1'b0;
    @(negedge clk_i);
    check("R2 hold", 16'h0033, 8'h00, 1'b0);
  endtask

  initial begin
    #1;
    t_reset();
    #10 rst_ni = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_sbc_zero();
    t_incdec();
    t_com();
    t_neg();
    t_eor();
    t_word();
    t_mul();
    t_unknown();
    t_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule